// File: doc/BRIEF.md
# Ring-Buffered SPI Flash Command Engine

This block is a register-driven SPI master that issues one serial-flash command each time software asks for one. Software loads an opcode register and a packed byte-count register. It places the payload bytes into a small ring buffer through a single data port, and each access to that port moves a 3-bit pointer forward by one. Software then writes the start bit and polls it until it reads back as zero.

The engine drives chip select low and shifts out the opcode and then the payload. It then clocks in the requested number of response bytes in SPI mode 0. Each response byte is stored in the same ring, at the positions that follow the payload bytes. The ring is never cleared, and both hardware and software move the same pointer. Software reads the response by resetting the pointer, skipping the payload bytes and reading on. A 2-bit speed field sets the SPI clock as a division of the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: The opcode register is at address 0x0 and the count register is at address 0x1. The count register holds the receive count in bits 7:4 and the transmit count (opcode not included) in bits 3:0. Both registers read back the value last written to them.
- R2: Writing 1 to bit 0 of address 0x2 starts a command. That bit reads 1 while the command runs and reads 0 once it has finished.
- R3: Every read or write of the data port at address 0xC moves the ring pointer forward by one, modulo 8. The pointer reads back in bits 2:0 of address 0xD. Writing address 0xD with bit 7 set returns the pointer to 0.
- R4: MOSI carries the opcode and then the transmit bytes, taken from the ring starting at the pointer's value at start. Each byte goes out MSB first. SCK idles low, MOSI changes after falling edges, and MISO is sampled on rising edges.
- R5: Received bytes are written into the ring, one after another, at the positions that follow the transmit bytes. The ring is never cleared. When a command ends, the pointer equals its start value plus the transmit count plus the receive count, modulo 8.
- R6: With a transmit count of 0, every requested receive byte is captured, including the last one.
- R7: A command produces exactly 8*(1+tx+rx) rising SCK edges. With a receive count of 0, no clocks are issued after the last transmit byte.
- R8: The speed code in bits 5:4 of address 0xD reads back as written. Each SCK half period lasts code+1 system clocks, so with a 132 MHz system clock codes 0 to 3 give 66, 33, 22 and 16.5 MHz.
- R9: Chip select falls one half period before the first rising SCK edge. It rises 2*(code+1) system clocks after the last falling SCK edge.
- R10: While a command runs, writes to addresses 0x0, 0x1, 0xC and 0xD are ignored. Accesses to the data port made during that time do not move the pointer.
- R11: A count field above 8 is treated as 8 when the command runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (moves the pointer on the data port) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from the address |
| spiSck | output | 1 | SPI clock, idles low |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with its default parameters: an 8-entry ring with a 3-bit pointer, 4-bit count fields and a 2-bit speed code. With these values a command's transmit and receive bytes together can exceed the ring length, so the bench reaches pointer wrap and response bytes that overwrite payload already sent. All four speed codes are small enough that the bench can measure SCK half periods and chip-select timing in system clocks. The clamped 17-byte command still fits easily inside the run.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [3:0] ADDR_OPCODE = 4'h0;
  localparam logic [3:0] ADDR_COUNT  = 4'h1;
  localparam logic [3:0] ADDR_CTRL   = 4'h2;
  localparam logic [3:0] ADDR_DATA   = 4'hC;
  localparam logic [3:0] ADDR_PTRSPD = 4'hD;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadOp;    // shift register <= opcode
    logic loadTx;    // shift register <= ring[ptr], ptr++
    logic loadZero;  // shift register <= 0 (receive byte)
    logic shift;     // shift left, inserting the sampled bit
    logic sample;    // capture MISO
    logic storeRx;   // ring[ptr] <= received byte, ptr++
  } engStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } engState_t;

endpackage

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4,
  parameter int SPD_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              busy,
  input  engStrobe_t        stb,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic [CNT_W-1:0]  txRaw,
  output logic [CNT_W-1:0]  rxRaw,
  output logic [SPD_W-1:0]  speed,
  output logic [PTR_W-1:0]  ringPtr,
  output logic [DATA_W-1:0] opcodeQ
);

  localparam int DEPTH = 2 ** PTR_W;

  logic [DATA_W-1:0] ring [DEPTH];
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] shReg;
  logic              rxBit;
  logic [DATA_W-1:0] shNext;

  logic hostIdle, wrOp, wrCnt, wrPtrSpd, dataWr, dataAcc;

  assign hostIdle = !busy;
  assign wrOp     = hostIdle && regWrEn && (regAddr == ADDR_OPCODE);
  assign wrCnt    = hostIdle && regWrEn && (regAddr == ADDR_COUNT);
  assign wrPtrSpd = hostIdle && regWrEn && (regAddr == ADDR_PTRSPD);
  assign dataWr   = hostIdle && regWrEn && (regAddr == ADDR_DATA);
  assign dataAcc  = hostIdle && (regWrEn || regRdEn) && (regAddr == ADDR_DATA);

  assign shNext = {shReg[DATA_W-2:0], rxBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ <= '0;
      countQ  <= '0;
      speed   <= '0;
    end else begin
      if (wrOp)     opcodeQ <= regWrData;
      if (wrCnt)    countQ  <= regWrData;
      if (wrPtrSpd) speed   <= regWrData[4 +: SPD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringPtr <= '0;
    end else if (wrPtrSpd && regWrData[DATA_W-1]) begin
      ringPtr <= '0;
    end else if (dataAcc || stb.loadTx || stb.storeRx) begin
      ringPtr <= ringPtr + 1'b1;
    end
  end

  // ring storage is never reset or cleared
  always_ff @(posedge clk) begin
    if (dataWr) begin
      ring[ringPtr] <= regWrData;
    end else if (stb.storeRx) begin
      ring[ringPtr] <= shNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rxBit <= 1'b0;
    end else begin
      if (stb.sample) rxBit <= spiMiso;
      if (stb.loadOp)        shReg <= opcodeQ;
      else if (stb.loadTx)   shReg <= ring[ringPtr];
      else if (stb.loadZero) shReg <= '0;
      else if (stb.shift)    shReg <= shNext;
    end
  end

  assign spiMosi = shReg[DATA_W-1];
  assign txRaw   = countQ[CNT_W-1:0];
  assign rxRaw   = countQ[2*CNT_W-1:CNT_W];

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_OPCODE: regRdData = opcodeQ;
      ADDR_COUNT:  regRdData = countQ;
      ADDR_CTRL:   regRdData = DATA_W'(busy);
      ADDR_DATA:   regRdData = ring[ringPtr];
      ADDR_PTRSPD: regRdData = DATA_W'({speed, 1'b0, ringPtr});
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_cmd_ctl.sv
module spi_cmd_ctl
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4,
  parameter int SPD_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] txRaw,
  input  logic [CNT_W-1:0] rxRaw,
  input  logic [SPD_W-1:0] speed,
  output logic             busy,
  output logic             spiSck,
  output logic             spiCsN,
  output engStrobe_t       stb
);

  localparam int MAX_CNT = 2 ** PTR_W;
  localparam int BYTE_W  = $clog2(2 * MAX_CNT + 2);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int TMR_W   = SPD_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  engState_t         state;
  logic [TMR_W-1:0]  tmr;
  logic [SPD_W-1:0]  spdLat;
  logic [BYTE_W-1:0] txLat, rxLat, byteIdx;
  logic [BIT_W-1:0]  bitIdx;

  logic tmrZero, lastBit, lastByte, curIsRx, nextIsRx;

  function automatic logic [BYTE_W-1:0] clampCnt(input logic [CNT_W-1:0] c);
    return (int'(c) > MAX_CNT) ? BYTE_W'(MAX_CNT) : BYTE_W'(c);
  endfunction

  assign tmrZero  = (tmr == '0);
  assign lastBit  = (bitIdx == LAST_BIT);
  assign lastByte = (byteIdx == txLat + rxLat);
  assign curIsRx  = (byteIdx > txLat);
  assign nextIsRx = (BYTE_W'(byteIdx + 1'b1) > txLat);

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: stb.loadOp = startReq;
      ST_LOW:  stb.sample = tmrZero;
      ST_HIGH: begin
        if (tmrZero) begin
          if (lastBit) begin
            stb.storeRx = curIsRx;
            if (!lastByte) begin
              stb.loadZero = nextIsRx;
              stb.loadTx   = !nextIsRx;
            end
          end else begin
            stb.shift = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      spiSck  <= 1'b0;
      spiCsN  <= 1'b1;
      tmr     <= '0;
      spdLat  <= '0;
      txLat   <= '0;
      rxLat   <= '0;
      byteIdx <= '0;
      bitIdx  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            busy    <= 1'b1;
            spiCsN  <= 1'b0;
            spdLat  <= speed;
            tmr     <= TMR_W'(speed);
            txLat   <= clampCnt(txRaw);
            rxLat   <= clampCnt(rxRaw);
            byteIdx <= '0;
            bitIdx  <= '0;
            state   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tmrZero) begin
            spiSck <= 1'b1;
            tmr    <= TMR_W'(spdLat);
            state  <= ST_HIGH;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_HIGH: begin
          if (tmrZero) begin
            spiSck <= 1'b0;
            if (lastBit) begin
              bitIdx <= '0;
              if (lastByte) begin
                tmr   <= {spdLat, 1'b1};
                state <= ST_TAIL;
              end else begin
                byteIdx <= byteIdx + 1'b1;
                tmr     <= TMR_W'(spdLat);
                state   <= ST_LOW;
              end
            end else begin
              bitIdx <= bitIdx + 1'b1;
              tmr    <= TMR_W'(spdLat);
              state  <= ST_LOW;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_TAIL: begin
          if (tmrZero) begin
            spiCsN <= 1'b1;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4,
  parameter int SPD_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);

  engStrobe_t        engStb;
  logic              engBusy;
  logic              startReq;
  logic [CNT_W-1:0]  txRaw, rxRaw;
  logic [SPD_W-1:0]  speed;
  logic [PTR_W-1:0]  ringPtr;
  logic [DATA_W-1:0] opcodeQ;

  assign startReq = regWrEn && (regAddr == ADDR_CTRL) && regWrData[0] && !engBusy;

  spi_cmd_ctl #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .SPD_W(SPD_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .txRaw(txRaw), .rxRaw(rxRaw), .speed(speed),
    .busy(engBusy), .spiSck(spiSck), .spiCsN(spiCsN), .stb(engStb)
  );

  spi_cmd_dp #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .SPD_W(SPD_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .busy(engBusy), .stb(engStb), .spiMiso(spiMiso), .spiMosi(spiMosi),
    .txRaw(txRaw), .rxRaw(rxRaw), .speed(speed), .ringPtr(ringPtr),
    .opcodeQ(opcodeQ)
  );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        regAddr,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              spiSck,
  input logic              spiCsN,
  input logic              busy,
  input logic [PTR_W-1:0]  ringPtr,
  input logic [DATA_W-1:0] opcodeQ
);

  p_sck_low_when_deselected_r4: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  p_cs_high_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (regWrEn || regRdEn) && regAddr == 4'hC)
      |=> ringPtr == PTR_W'($past(ringPtr) + 1'b1));

  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && regWrEn && regAddr == 4'hD && regWrData[DATA_W-1]) |=> ringPtr == '0);

  p_opcode_locked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == 4'h0) |=> $stable(opcodeQ));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regWrData(regWrData), .spiSck(spiSck), .spiCsN(spiCsN), .busy(engBusy),
  .ringPtr(ringPtr), .opcodeQ(opcodeQ)
);

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;

  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       spiSck, spiCsN, spiMosi;
  logic       spiMiso = 1'b0;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_cmd_engine dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // ---------------- flash model ----------------
  logic [7:0] curOp = 8'h00;
  logic [7:0] mosiCap [32];
  int  sBit = 0;
  int  sckRises = 0;
  time tCsFall = 0, tCsRise = 0, tLastFall = 0, tRise0 = 0, tRise1 = 0;

  function automatic logic [7:0] respByte(input logic [7:0] op, input int j);
    return op ^ 8'(8'h3C + j * 29);
  endfunction

  function automatic logic respBit(input int n);
    logic [7:0] b;
    b = respByte(curOp, n / 8);
    return b[7 - (n % 8)];
  endfunction

  always @(negedge spiCsN) begin
    tCsFall = $time;
    sBit = 0;
    sckRises = 0;
    spiMiso = respBit(0);
  end
  always @(posedge spiCsN) tCsRise = $time;
  always @(posedge spiSck) begin
    if (sBit == 0) tRise0 = $time;
    if (sBit == 1) tRise1 = $time;
    if (sBit < 256) mosiCap[(sBit / 8) % 32][7 - (sBit % 8)] = spiMosi;
    sBit++;
    sckRises++;
  end
  always @(negedge spiSck) begin
    tLastFall = $time;
    spiMiso = respBit(sBit);
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  logic [7:0] mRing [8];
  bit         mValid [8];

  task automatic runCmd(input logic [7:0] op, input int txRaw, input int rxRaw,
                        input int spd, input int off, input bit poke, input string tag);
    int txE, rxE, p, guard;
    logic [7:0] d, b;
    logic [7:0] expTx [8];
    logic [7:0] spdW;
    txE = (txRaw > 8) ? 8 : txRaw;
    rxE = (rxRaw > 8) ? 8 : rxRaw;
    spdW = 8'(spd << 4);
    regWrite(4'hD, 8'h80 | spdW);
    repeat (off) regRead(4'hC, d);
    regWrite(4'h0, op);
    regWrite(4'h1, {4'(rxRaw), 4'(txRaw)});
    regRead(4'h0, d); chk(d == op, "R1", "opcode readback", d, op);
    regRead(4'h1, d); chk(d == {4'(rxRaw), 4'(txRaw)}, "R1", "count readback", d, {4'(rxRaw), 4'(txRaw)});
    p = off;
    for (int k = 0; k < txE; k++) begin
      b = 8'($urandom);
      regWrite(4'hC, b);
      mRing[p % 8] = b; mValid[p % 8] = 1'b1; p++;
    end
    regRead(4'hD, d); chk(d[2:0] == 3'(p), "R3", "pointer after fill", d[2:0], 3'(p));
    regWrite(4'hD, 8'h80 | spdW);
    regRead(4'hD, d); chk(d[2:0] == 3'd0, "R3", "pointer reset", d[2:0], 0);
    repeat (off) regRead(4'hC, d);
    for (int k = 0; k < txE; k++) expTx[k] = mRing[(off + k) % 8];
    curOp = op;
    regWrite(4'h2, 8'h01);
    regRead(4'h2, d); chk(d[0] == 1'b1, "R2", "busy while running", d[0], 1);
    if (poke) begin
      regWrite(4'h0, ~op);
      regWrite(4'h1, 8'h00);
      regWrite(4'hC, 8'hEE);
      regRead(4'hC, d);
      regWrite(4'hD, 8'h80);
    end
    guard = 0;
    do begin
      regRead(4'h2, d);
      guard++;
    end while (d[0] && guard < 5000);
    chk(d[0] == 1'b0, "R2", "busy cleared", d[0], 0);
    chk(sckRises == 8 * (1 + txE + rxE), "R7", "sck rising edges", sckRises, 8 * (1 + txE + rxE));
    chk(mosiCap[0] == op, "R4", "opcode on mosi", mosiCap[0], op);
    for (int k = 0; k < txE; k++)
      chk(mosiCap[1 + k] == expTx[k], "R4", "payload on mosi", mosiCap[1 + k], expTx[k]);
    chk(tRise1 - tRise0 == time'(2 * (spd + 1) * CLK_NS), "R8", "sck period",
        int'(tRise1 - tRise0), 2 * (spd + 1) * CLK_NS);
    chk(tRise0 - tCsFall == time'((spd + 1) * CLK_NS), "R9", "cs setup",
        int'(tRise0 - tCsFall), (spd + 1) * CLK_NS);
    chk(tCsRise - tLastFall == time'(2 * (spd + 1) * CLK_NS), "R9", "cs hold",
        int'(tCsRise - tLastFall), 2 * (spd + 1) * CLK_NS);
    p = off + txE;
    for (int k = 0; k < rxE; k++) begin
      mRing[p % 8] = respByte(op, 1 + txE + k); mValid[p % 8] = 1'b1; p++;
    end
    regRead(4'hD, d);
    chk(d[2:0] == 3'(p), tag, "pointer at end", d[2:0], 3'(p));
    chk(d[5:4] == 2'(spd), "R8", "speed readback", d[5:4], spd);
    if (poke) begin
      regRead(4'h0, d); chk(d == op, "R10", "opcode kept", d, op);
      regRead(4'h1, d); chk(d == {4'(rxRaw), 4'(txRaw)}, "R10", "count kept", d, {4'(rxRaw), 4'(txRaw)});
    end
    regWrite(4'hD, 8'h80 | spdW);
    for (int i = 0; i < 8; i++) begin
      regRead(4'hC, d);
      if (mValid[i]) chk(d == mRing[i], tag, "ring content", d, mRing[i]);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(spiCsN == 1'b1, "R9", "reset cs high", spiCsN, 1);
    chk(spiSck == 1'b0, "R4", "reset sck low", spiSck, 0);
    regRead(4'h2, d); chk(d == 8'h00, "R2", "reset idle", d, 0);
    regRead(4'hD, d); chk(d == 8'h00, "R3", "reset pointer and speed", d, 0);

    runCmd(8'h9F, 0, 5, 1, 0, 1'b0, "R6");      // no payload, all response bytes kept
    runCmd(8'h06, 0, 0, 0, 0, 1'b0, "R7");      // opcode only
    runCmd(8'h02, 3, 0, 2, 2, 1'b0, "R7");      // payload only, no receive clocks
    runCmd(8'h0B, 15, 15, 0, 3, 1'b0, "R11");   // counts clamp to 8 each
    runCmd(8'h05, 2, 2, 3, 5, 1'b1, "R10");     // writes during busy ignored
    runCmd(8'h03, 8, 8, 1, 7, 1'b0, "R5");      // full ring wrap
    for (int n = 0; n < 18; n++)
      runCmd(8'($urandom), int'($urandom % 9), int'($urandom % 9),
             int'($urandom % 4), int'($urandom % 8), 1'b0, "R5");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule